// File: doc/BRIEF.md
# PCI Sideband Reset and Interrupt Controller

This block manages the sideband wires of a PCI bridge: the bus reset line and the four interrupt lines A to D. Software drives the reset pad and interrupt line A through a small register port. Every line is watched through a synchronizer, and each assertion is latched into a sticky status bit that software clears by writing ones. A mask register selects which latched events raise a single registered interrupt towards the local core. A reset raised by software and a reset arriving from outside both lead to one internal reset output for the bridge logic.

All pins are active low and modelled as tri-state triples (value out, output enable, value in). All register bits are active high. A 1 in a control bit pulls its pin low, and a status bit reads 1 when its line has been seen low. The host/device mode input does not gate any drive path. Software can read the mode back.

Top module: `pci_sb_ctrl`

## Requirements
- R1: After reset the CTRL (address 0), STAT (address 1) and MASK (address 2) registers read 0 (the mode input low), both pad output enables are low, and `core_irq_o` and `pci_core_rst_o` are low.
- R2: `pci_rst_oe_o` is high only while CTRL bit 0 (reset enable) and CTRL bit 1 (reset assert) are both 1, and the reset pad value is low whenever it is enabled.
- R3: CTRL bit 2 set makes `pci_inta_oe_o` high with `pci_inta_n_o` low, whatever the mode input is.
- R4: STAT bit 0 latches the reset line, and STAT bits 1 to 4 latch interrupt lines A to D. A line held low for one clock sets its bit three clocks after it first goes low, and the bit stays set after the line returns high.
- R5: Writing STAT clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: When a line is seen asserted in the same cycle that software writes 1 to its status bit, the bit stays set.
- R7: `core_irq_o` equals the OR of (STAT AND MASK) with one clock of delay. MASK uses the same bit positions as STAT.
- R8: `pci_core_rst_o` is the registered OR of the software reset (the pad output enable) and the synchronized external reset line. It rises three clocks after the external line first goes low, and one clock after the CTRL write that enables the pad.
- R9: The mode input reads back in CTRL bit 7 and does not change the pad drive, the status capture or the reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| host_mode_i | input | 1 | 1 = host, 0 = device |
| pci_rst_n_i | input | 1 | Reset pad input |
| pci_rst_n_o | output | 1 | Reset pad output value |
| pci_rst_oe_o | output | 1 | Reset pad output enable |
| pci_int_n_i | input | 4 | Interrupt pad inputs, bit 0 = line A |
| pci_inta_n_o | output | 1 | Line A pad output value |
| pci_inta_oe_o | output | 1 | Line A pad output enable |
| pci_core_rst_o | output | 1 | Internal reset for the bridge logic |
| core_irq_o | output | 1 | Masked interrupt to the local core |

## Verification
The case that needs care is a status bit being set by a synchronized line sample and cleared by a software write in the same cycle. The bench holds interrupt line C low and writes ones to the whole STAT register. Only bit 3 may survive that write, and it must clear once the line has been released. The bench also drives the reset pad from software and lets the line loop back. Its own drive then lands in status bit 0 while the internal reset is still high, and the bench checks that both happen with the expected latency.

// File: rtl/pci_sb_pkg.sv
package pci_sb_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_MASK = 2'd2
  } reg_addr_e;

  localparam int CTRL_MODE_BIT = 7;

  typedef struct packed {
    logic inta_drv;
    logic rst_assert;
    logic rst_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pci_sb_sync.sv
module pci_sb_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pci_sb_regs.sv
module pci_sb_regs
  import pci_sb_pkg::*;
#(
  parameter int NSTAT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSTAT-1:0]  set_i,
  input  logic              mode_i,
  output ctrl_t             ctrl_o,
  output logic [NSTAT-1:0]  stat_o,
  output logic [NSTAT-1:0]  mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t            ctrl_q;
  logic [NSTAT-1:0] stat_q, mask_q, clr;
  logic             wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:NSTAT];
  assign clr = (we_i && addr_i == A_STAT) ? wdata_i[NSTAT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i[NSTAT-1:0];
      // set takes priority over a same-cycle clear
      stat_q <= (stat_q & ~clr) | set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_W-1:0]   = ctrl_q;
        rdata_o[CTRL_MODE_BIT] = mode_i;
      end
      A_STAT:  rdata_o[NSTAT-1:0] = stat_q;
      A_MASK:  rdata_o[NSTAT-1:0] = mask_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/pci_sb_ctrl.sv
module pci_sb_ctrl
  import pci_sb_pkg::*;
#(
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               host_mode_i,
  input  logic               pci_rst_n_i,
  output logic               pci_rst_n_o,
  output logic               pci_rst_oe_o,
  input  logic [NUM_INT-1:0] pci_int_n_i,
  output logic               pci_inta_n_o,
  output logic               pci_inta_oe_o,
  output logic               pci_core_rst_o,
  output logic               core_irq_o
);
  localparam int NSTAT = NUM_INT + 1;

  logic [NSTAT-1:0] seen, stat_q, mask_q;
  ctrl_t            ctrl;
  logic             sw_rst, core_rst_q, irq_q;

  // pins are active low, status bits active high
  pci_sb_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~{pci_int_n_i, pci_rst_n_i}),
    .q_o   (seen)
  );

  pci_sb_regs #(.NSTAT(NSTAT)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .set_i  (seen),
    .mode_i (host_mode_i),
    .ctrl_o (ctrl),
    .stat_o (stat_q),
    .mask_o (mask_q),
    .rdata_o(reg_rdata_o)
  );

  assign sw_rst        = ctrl.rst_en & ctrl.rst_assert;
  assign pci_rst_oe_o  = sw_rst;
  assign pci_rst_n_o   = 1'b0;
  assign pci_inta_oe_o = ctrl.inta_drv;
  assign pci_inta_n_o  = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_rst_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      core_rst_q <= sw_rst | seen[0];
      irq_q      <= |(stat_q & mask_q);
    end
  end

  assign pci_core_rst_o = core_rst_q;
  assign core_irq_o     = irq_q;
endmodule

// File: rtl/pci_sb_ctrl_chk.sv
module pci_sb_ctrl_chk #(
  parameter int NSTAT = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [2:0]       ctrl_wr_i,
  input logic [NSTAT-1:0] clr_wr_i,
  input logic             pci_rst_n_o,
  input logic             pci_rst_oe_o,
  input logic             pci_inta_oe_o,
  input logic             pci_core_rst_o,
  input logic             core_irq_o,
  input logic [NSTAT-1:0] seen_i,
  input logic [NSTAT-1:0] stat_i,
  input logic [NSTAT-1:0] mask_i
);
  logic             ctrl_wr;
  logic [NSTAT-1:0] clr_eff;
  assign ctrl_wr = we_i && addr_i == 2'd0;
  assign clr_eff = (we_i && addr_i == 2'd1) ? clr_wr_i : '0;

  p_pad_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_rst_oe_o |-> !pci_rst_n_o);
  p_pad_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && ctrl_wr_i[1:0] == 2'b11) |=> pci_rst_oe_o);
  p_pad_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && ctrl_wr_i[1:0] != 2'b11) |=> !pci_rst_oe_o);
  p_inta_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (pci_inta_oe_o == $past(ctrl_wr_i[2])));
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|seen_i) |=> ((stat_i & $past(seen_i)) == $past(seen_i)));
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_i) |=> (((($past(stat_i) & ~$past(clr_eff))) & ~stat_i) == '0));
  p_irq_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & mask_i)) |=> core_irq_o);
  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_i & mask_i)) |=> !core_irq_o);
  p_sw_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_rst_oe_o |=> pci_core_rst_o);
  p_ext_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_i[0] |=> pci_core_rst_o);
endmodule

bind pci_sb_ctrl pci_sb_ctrl_chk #(.NSTAT(NUM_INT + 1)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (reg_we_i),
  .addr_i        (reg_addr_i),
  .ctrl_wr_i     (reg_wdata_i[2:0]),
  .clr_wr_i      (reg_wdata_i[NUM_INT:0]),
  .pci_rst_n_o   (pci_rst_n_o),
  .pci_rst_oe_o  (pci_rst_oe_o),
  .pci_inta_oe_o (pci_inta_oe_o),
  .pci_core_rst_o(pci_core_rst_o),
  .core_irq_o    (core_irq_o),
  .seen_i        (seen),
  .stat_i        (stat_q),
  .mask_i        (mask_q)
);

// File: tb/tb_pci_sb_ctrl.sv
`timescale 1ns/1ps
module tb_pci_sb_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       mode = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic [3:0] ext_int_n = 4'hF;
  logic       rst_n_o, rst_oe, inta_n_o, inta_oe, core_rst, irq;
  logic       rst_line;
  logic [3:0] int_line;
  int         nvec = 0, nfail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  // open-drain style pad model with pull-up
  assign rst_line = rst_oe  ? rst_n_o  : ext_rst_n;
  assign int_line = {ext_int_n[3:1], inta_oe ? inta_n_o : ext_int_n[0]};

  pci_sb_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .host_mode_i(mode),
    .pci_rst_n_i(rst_line), .pci_rst_n_o(rst_n_o), .pci_rst_oe_o(rst_oe),
    .pci_int_n_i(int_line), .pci_inta_n_o(inta_n_o), .pci_inta_oe_o(inta_oe),
    .pci_core_rst_o(core_rst), .core_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5 d = rdata;
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog act=%h exp=%h", 8'h1, 8'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 stat", v, 8'h00);
    rd(2'd2, v); chk("R1 mask", v, 8'h00);
    chk("R1 pad oe", {6'd0, rst_oe, inta_oe}, 8'h00);
    chk("R1 outs", {6'd0, irq, core_rst}, 8'h00);

    // R2 R3 R8 R9 control sweep over every CTRL value and both modes
    for (int md = 0; md < 2; md++) begin
      for (int c = 0; c < 8; c++) begin
        mode = md[0];
        wr(2'd0, 8'(c));
        chk("R2 pad oe", {7'd0, rst_oe}, {7'd0, c[0] & c[1]});
        if (rst_oe) chk("R2 pad low", {7'd0, rst_n_o}, 8'h00);
        chk("R3 inta oe", {7'd0, inta_oe}, {7'd0, c[2]});
        if (inta_oe) chk("R3 inta low", {7'd0, inta_n_o}, 8'h00);
        rd(2'd0, v); chk("R9 ctrl readback", v, {md[0], 4'd0, 3'(c)});
        cyc(1);
        chk("R8 sw rst", {7'd0, core_rst}, {7'd0, c[0] & c[1]});
        cyc(3);
        rd(2'd1, v); chk("R4 loopback stat", v, {6'd0, c[2], c[0] & c[1]});
        chk("R8 sw rst held", {7'd0, core_rst}, {7'd0, c[0] & c[1]});
        wr(2'd0, 8'h00);
        cyc(5);
        wr(2'd1, 8'h1F);
        rd(2'd1, v); chk("R5 clear", v, 8'h00);
      end
    end
    mode = 1'b0;

    // R4 R7 sweep: every line pattern against every mask
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 32; m++) begin
        wr(2'd2, 8'(m));
        wr(2'd1, 8'h1F);
        cyc(1);
        chk("R7 irq idle", {7'd0, irq}, 8'h00);
        ext_rst_n = ~p[0];
        ext_int_n = ~4'(p >> 1);
        cyc(1);
        ext_rst_n = 1'b1;
        ext_int_n = 4'hF;
        cyc(4);
        rd(2'd1, v); chk("R4 sticky capture", v, 8'(p));
        chk("R7 irq", {7'd0, irq}, {7'd0, |(5'(p) & 5'(m))});
        wr(2'd2, 8'(~m & 31));
        cyc(1);
        chk("R7 irq remask", {7'd0, irq}, {7'd0, |(5'(p) & ~5'(m))});
      end
    end
    wr(2'd2, 8'h00);

    // R5 selective clear
    ext_rst_n = 1'b0; ext_int_n = 4'h0;
    cyc(1);
    ext_rst_n = 1'b1; ext_int_n = 4'hF;
    cyc(4);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R5 clear one", v, 8'h1D);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R5 clear none", v, 8'h1D);
    wr(2'd1, 8'h1F);

    // R6 set beats clear while line C held low
    ext_int_n[2] = 1'b0;
    cyc(4);
    wr(2'd1, 8'h1F);
    rd(2'd1, v); chk("R6 set wins", v, 8'h08);
    ext_int_n[2] = 1'b1;
    cyc(4);
    wr(2'd1, 8'h1F);
    rd(2'd1, v); chk("R6 clear after release", v, 8'h00);

    // R8 external reset latency
    ext_rst_n = 1'b0;
    cyc(2);
    chk("R8 ext rst early", {7'd0, core_rst}, 8'h00);
    cyc(1);
    chk("R8 ext rst", {7'd0, core_rst}, 8'h01);
    ext_rst_n = 1'b1;
    cyc(4);
    chk("R8 ext rst release", {7'd0, core_rst}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule